// File: doc/BRIEF.md
# Mailbox Requester Sequencing Engine

This block is a hardware master that runs one full request/response exchange against a data-object mailbox. It reaches the mailbox through a simple register port with four word registers: control, status, write data and read data. A local client supplies a vendor ID, an object type and the request payload, which the engine reads out of a client-owned buffer. The client also gives a response buffer capacity. The engine first checks the mailbox status. It then pushes the header, the length and the payload, and starts the mailbox. It waits for a response, polling at a fixed cadence until a deadline, and then consumes that response into the client's response buffer.

The response is validated as it arrives: the header must echo the request and the length must be sane. Extra payload that does not fit the buffer is drained and dropped. Any fault sends the engine through an abort sequence, which waits for the mailbox to settle. If the mailbox never settles, it is marked permanently dead. Each transaction ends with a one-cycle completion pulse carrying a result code and, on success, the stored byte count.

Top module: `mbox_requester`

## Requirements
- R1: A start with a request size that is not a multiple of 4 bytes, or above REQ_DEPTH*4, or a response capacity below 4 bytes or above RSP_DEPTH*4, completes with result 3 (invalid) and makes no register access.
- R2: The first access reads status (address 1). If the busy flag (bit 0) is set, the result is 1 (busy). Otherwise, if the error flag (bit 2) is set, the result is 2 (I/O error). In both cases no request word is written and the abort path runs.
- R3: The request is written to address 2 in this order: a header with vendor in bits 15:0 and type in bits 23:16, then a length of 2 plus the payload word count, then each payload word. After that comes a write of bit 31 (go) to control (address 0). A bus request holds its address, direction and data until acknowledged.
- R4: After go, status is read at once and then every POLL_CYC idle cycles, so successive reads are POLL_CYC+2 cycles apart. An error flag seen while polling gives result 2 through the abort path.
- R5: If no ready flag (status bit 31) is seen within TIMEOUT_CYC cycles of go, the result is 2 through the abort path.
- R6: The first response word read from address 3 must carry the requested vendor and type, or the result is 2.
- R7: Every response word is consumed by a read of address 3 followed by a write of zero to address 3.
- R8: A response length (second word, bits 17:0) below 2 or above MAX_LEN gives result 2.
- R9: Payload words are stored up to the response capacity, and the rest are read and acknowledged. On success the result is 0 and the count is the stored word count times 4.
- R10: Before the last stored word is acknowledged, status must still show ready. After all words are consumed, a status with the error flag set gives result 2.
- R11: The abort path writes bit 0 to control and then polls status until error and busy are both clear. If that does not happen within TIMEOUT_CYC cycles, a sticky dead flag is set. While dead, a valid start completes with result 2 on the next cycle and makes no access.
- R12: A cancel pulse during a transaction ends it through the abort path with result 2.
- R13: After reset, done, dead and bus request are low. Completion is a single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| cancel | input | 1 | Force abort of the running transaction |
| req_vid | input | 16 | Protocol vendor ID |
| req_type | input | 8 | Protocol object type |
| req_bytes | input | clog2(REQ_DEPTH*4+1) | Request payload size in bytes |
| rsp_bytes | input | clog2(RSP_DEPTH*4+1) | Response buffer capacity in bytes |
| req_idx | output | clog2(REQ_DEPTH) | Request buffer word index |
| req_data | input | 32 | Request buffer word at req_idx |
| rsp_we | output | 1 | Response buffer write enable |
| rsp_idx | output | clog2(RSP_DEPTH) | Response buffer word index |
| rsp_data | output | 32 | Response word to store |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 2 | 0 control, 1 status, 2 write data, 3 read data |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access acknowledge (read data valid) |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 busy, 2 I/O error, 3 invalid |
| rsp_count | output | clog2(RSP_DEPTH*4+1) | Stored response bytes |
| dead | output | 1 | Mailbox marked unusable |
| active | output | 1 | Transaction in progress |

## Verification
The bench drives a behavioural mailbox and tries a fitting response, an oversized one, and an empty request paired with a bare two-word response. These cases separate plain storing from truncation with draining and from the zero-payload edge. Separate runs inject a busy flag, an error flag before send, an error flag after go, a wrong header, lengths of 1 and 70, a ready flag that drops mid-read, an error raised on the final word, silence until the deadline, and a cancel pulse. Each of these must end with the right code, and the busy case must not be confused with the error cases. A mailbox whose error never clears must leave the engine dead and refusing further work without touching the port.

// File: rtl/mbox_requester.sv
module mbox_requester #(
  parameter int REQ_DEPTH   = 16,
  parameter int RSP_DEPTH   = 16,
  parameter int TIMEOUT_CYC = 1_000_000,
  parameter int POLL_CYC    = TIMEOUT_CYC / 128,
  parameter int MAX_LEN     = 1024
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             cancel,
  input  logic [15:0]                      req_vid,
  input  logic [7:0]                       req_type,
  input  logic [$clog2(REQ_DEPTH*4+1)-1:0] req_bytes,
  input  logic [$clog2(RSP_DEPTH*4+1)-1:0] rsp_bytes,
  output logic [$clog2(REQ_DEPTH)-1:0]     req_idx,
  input  logic [31:0]                      req_data,
  output logic                             rsp_we,
  output logic [$clog2(RSP_DEPTH)-1:0]     rsp_idx,
  output logic [31:0]                      rsp_data,
  output logic                             bus_req,
  output logic                             bus_we,
  output logic [1:0]                       bus_addr,
  output logic [31:0]                      bus_wdata,
  input  logic                             bus_ack,
  input  logic [31:0]                      bus_rdata,
  output logic                             done,
  output logic [1:0]                       result,
  output logic [$clog2(RSP_DEPTH*4+1)-1:0] rsp_count,
  output logic                             dead,
  output logic                             active
);
  localparam int QIW = $clog2(REQ_DEPTH);
  localparam int RIW = $clog2(RSP_DEPTH);
  localparam int SBW = $clog2(RSP_DEPTH*4+1);
  localparam int TW  = $clog2(TIMEOUT_CYC+1);
  localparam int PW  = $clog2(POLL_CYC+1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_WR = 2'd2, A_RD = 2'd3;
  localparam logic [1:0] R_OK = 2'd0, R_BUSY = 2'd1, R_IO = 2'd2, R_INVAL = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_HDR, S_LEN, S_PAY, S_GO, S_POLL, S_PWAIT,
    S_H1, S_H1A, S_H2, S_H2A, S_DAT, S_RDY, S_DACK, S_FIN,
    S_AB, S_AWAIT, S_ARD, S_END
  } st_t;

  st_t             st;
  logic [15:0]     vid_q;
  logic [7:0]      typ_q;
  logic [QIW:0]    nreq;
  logic [17:0]     ncap, len_q, nstore, idx;
  logic [TW-1:0]   tmo;
  logic [PW-1:0]   pcnt;
  logic [1:0]      code_q;
  logic [SBW-1:0]  cnt_q;
  logic            dead_q, cxl_q;

  logic fire, bad, normal, tmo_up, hdr_ok;
  logic [17:0] rem, fit;

  assign fire   = bus_req & bus_ack;
  assign bad    = (req_bytes[1:0] != 2'd0) || (int'(req_bytes) > REQ_DEPTH*4) ||
                  (int'(rsp_bytes) < 4) || (int'(rsp_bytes) > RSP_DEPTH*4);
  assign normal = !(st inside {S_IDLE, S_AB, S_AWAIT, S_ARD, S_END});
  assign tmo_up = (tmo == TW'(TIMEOUT_CYC));
  assign hdr_ok = (bus_rdata[15:0] == vid_q) && (bus_rdata[23:16] == typ_q);
  assign rem    = len_q - 18'd2;
  assign fit    = (rem < ncap) ? rem : ncap;

  assign req_idx   = idx[QIW-1:0];
  assign rsp_idx   = idx[RIW-1:0];
  assign rsp_data  = bus_rdata;
  assign rsp_we    = (st == S_DAT) && fire && (idx < nstore);
  assign done      = (st == S_END);
  assign result    = code_q;
  assign rsp_count = cnt_q;
  assign dead      = dead_q;
  assign active    = (st != S_IDLE);

  always_comb begin
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_STAT; bus_wdata = 32'd0;
    case (st)
      S_CHK, S_POLL, S_RDY, S_FIN, S_ARD: ;
      S_HDR:  begin bus_we = 1'b1; bus_addr = A_WR; bus_wdata = {8'd0, typ_q, vid_q}; end
      S_LEN:  begin bus_we = 1'b1; bus_addr = A_WR; bus_wdata = 32'(nreq) + 32'd2; end
      S_PAY:  begin bus_we = 1'b1; bus_addr = A_WR; bus_wdata = req_data; end
      S_GO:   begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h8000_0000; end
      S_AB:   begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0000_0001; end
      S_H1, S_H2, S_DAT: bus_addr = A_RD;
      S_H1A, S_H2A, S_DACK: begin bus_we = 1'b1; bus_addr = A_RD; end
      default: bus_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; vid_q <= '0; typ_q <= '0; nreq <= '0; ncap <= '0;
      len_q <= '0; nstore <= '0; idx <= '0; tmo <= '0; pcnt <= '0;
      code_q <= R_OK; cnt_q <= '0; dead_q <= 1'b0; cxl_q <= 1'b0;
    end else begin
      if (!tmo_up) tmo <= tmo + 1'b1;
      if (normal && cancel) cxl_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          vid_q <= req_vid; typ_q <= req_type; cnt_q <= '0; cxl_q <= 1'b0;
          nreq <= (QIW+1)'(req_bytes >> 2);
          ncap <= 18'(rsp_bytes >> 2);
          if (bad)         begin code_q <= R_INVAL; st <= S_END; end
          else if (dead_q) begin code_q <= R_IO;    st <= S_END; end
          else st <= S_CHK;
        end
        S_CHK: if (fire) begin
          if (bus_rdata[0])      begin code_q <= R_BUSY; st <= S_AB; end
          else if (bus_rdata[2]) begin code_q <= R_IO;   st <= S_AB; end
          else st <= S_HDR;
        end
        S_HDR: if (fire) st <= S_LEN;
        S_LEN: if (fire) begin idx <= '0; st <= (nreq == '0) ? S_GO : S_PAY; end
        S_PAY: if (fire) begin
          idx <= idx + 18'd1;
          if (idx == 18'(nreq) - 18'd1) st <= S_GO;
        end
        S_GO: if (fire) begin tmo <= '0; st <= S_POLL; end
        S_POLL: if (fire) begin
          if (bus_rdata[2])       begin code_q <= R_IO; st <= S_AB; end
          else if (bus_rdata[31]) st <= S_H1;
          else if (tmo_up)        begin code_q <= R_IO; st <= S_AB; end
          else begin pcnt <= '0; st <= S_PWAIT; end
        end
        S_PWAIT: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PW'(POLL_CYC-1)) st <= S_POLL;
        end
        S_H1: if (fire) begin
          if (hdr_ok) st <= S_H1A;
          else begin code_q <= R_IO; st <= S_AB; end
        end
        S_H1A: if (fire) st <= S_H2;
        S_H2:  if (fire) begin len_q <= bus_rdata[17:0]; st <= S_H2A; end
        S_H2A: if (fire) begin
          if (len_q < 18'd2 || len_q > 18'(MAX_LEN)) begin code_q <= R_IO; st <= S_AB; end
          else begin
            len_q <= rem; nstore <= fit; idx <= '0;
            st <= (rem == '0) ? S_FIN : S_DAT;
          end
        end
        S_DAT: if (fire) st <= (idx == nstore - 18'd1) ? S_RDY : S_DACK;
        S_RDY: if (fire) begin
          if (bus_rdata[31]) st <= S_DACK;
          else begin code_q <= R_IO; st <= S_AB; end
        end
        S_DACK: if (fire) begin
          idx <= idx + 18'd1;
          st  <= (idx + 18'd1 == len_q) ? S_FIN : S_DAT;
        end
        S_FIN: if (fire) begin
          if (bus_rdata[2]) begin code_q <= R_IO; st <= S_AB; end
          else begin code_q <= R_OK; cnt_q <= SBW'({nstore, 2'b00}); st <= S_END; end
        end
        S_AB: if (fire) begin tmo <= '0; pcnt <= '0; st <= S_AWAIT; end
        S_AWAIT: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PW'(POLL_CYC-1)) st <= S_ARD;
        end
        S_ARD: if (fire) begin
          if (!bus_rdata[2] && !bus_rdata[0]) st <= S_END;
          else if (tmo_up) begin dead_q <= 1'b1; st <= S_END; end
          else begin pcnt <= '0; st <= S_AWAIT; end
        end
        default: st <= S_IDLE;
      endcase
      if (normal && (cxl_q || cancel) && (fire || st == S_PWAIT)) begin
        code_q <= R_IO; st <= S_AB;
      end
    end
  end

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_dead_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead);
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && start && bad |=> done && (result == R_INVAL) && !bus_req);
  p_dead_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && start && !bad && dead |=> done && (result == R_IO) && !bus_req);
  p_store_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> bus_ack && !bus_we && (bus_addr == A_RD));
endmodule

// File: tb/mbox_requester_bench.sv
module mbox_requester_bench;
  localparam int CLK_P = 10;
  localparam int TMO = 512, POLL = 4, MAXL = 64, QD = 8, SD = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cancel = 1'b0;
  logic [15:0] vid = '0;
  logic [7:0]  typ = '0;
  logic [5:0]  qb = '0, sb = '0;
  logic [2:0]  req_idx, rsp_idx;
  logic [31:0] req_data, rsp_data, bus_wdata;
  logic        rsp_we, bus_req, bus_we, done, dead, active;
  logic [1:0]  bus_addr, result;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [5:0]  rsp_count;

  always #(CLK_P/2) clk = ~clk;

  mbox_requester #(.REQ_DEPTH(QD), .RSP_DEPTH(SD), .TIMEOUT_CYC(TMO),
                   .POLL_CYC(POLL), .MAX_LEN(MAXL)) u_mbox_requester (
    .clk, .rst_n, .start, .cancel, .req_vid(vid), .req_type(typ),
    .req_bytes(qb), .rsp_bytes(sb), .req_idx, .req_data, .rsp_we, .rsp_idx,
    .rsp_data, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .done, .result, .rsp_count, .dead, .active);

  logic [31:0] req_mem [QD];
  logic [31:0] rsp_mem [SD];
  assign req_data = req_mem[req_idx];
  always @(posedge clk) if (rsp_we) rsp_mem[rsp_idx] <= rsp_data;

  bit m_busy, m_err, m_never, m_err_go, m_kill, m_killed, m_drain_err, m_stuck, go_seen;
  int pend, rdy_delay, n_abort, n_ack, cyc;
  logic [31:0] rq [$];
  logic [33:0] wlog [$];
  int stat_t [$];

  always @(posedge clk) begin
    cyc++;
    if (pend > 0) pend--;
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (!bus_we) begin
        if (bus_addr == 2'd1) begin
          stat_t.push_back(cyc);
          bus_rdata <= {go_seen && !m_never && !m_killed && pend == 0 && rq.size() > 0,
                        28'd0, m_err, 1'b0, m_busy};
        end else if (bus_addr == 2'd3) bus_rdata <= (rq.size() > 0) ? rq[0] : 32'd0;
        else bus_rdata <= 32'd0;
      end else begin
        wlog.push_back({bus_addr, bus_wdata});
        if (bus_addr == 2'd0) begin
          if (bus_wdata[31]) begin go_seen = 1; pend = rdy_delay; if (m_err_go) m_err = 1; end
          if (bus_wdata[0]) begin
            n_abort++; rq.delete(); go_seen = 0;
            if (!m_stuck) begin m_err = 0; m_busy = 0; end
          end
        end else if (bus_addr == 2'd3) begin
          n_ack++;
          if (rq.size() > 0) void'(rq.pop_front());
          if (m_kill) m_killed = 1;
          if (m_drain_err && rq.size() == 0) m_err = 1;
        end
      end
    end
  end

  typedef struct { logic [1:0] code; int cnt; string tag; } exp_t;
  exp_t exp_q [$];
  int n_chk = 0, n_bad = 0, n_done = 0, n_seen = 0, t_done = 0, t_start = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R13 unexpected done", int'(result), -1);
      else begin
        e = exp_q.pop_front();
        chk(result == e.code, e.tag, int'(result), int'(e.code));
        if (e.code == 2'd0) chk(int'(rsp_count) == e.cnt, {e.tag, " count"}, int'(rsp_count), e.cnt);
      end
      n_done++;
      t_done = cyc;
    end
  end

  task automatic clear_model();
    m_busy = 0; m_err = 0; m_never = 0; m_err_go = 0; m_kill = 0; m_killed = 0;
    m_drain_err = 0; m_stuck = 0; go_seen = 0; pend = 0; rdy_delay = 10;
    rq.delete();
  endtask

  task automatic kick(input logic [15:0] v, input logic [7:0] t, input int qbytes,
                      input int sbytes, input logic [1:0] code, input int cnt, input string tag);
    exp_t e;
    @(negedge clk);
    vid = v; typ = t; qb = 6'(qbytes); sb = 6'(sbytes);
    wlog.delete(); stat_t.delete(); n_ack = 0; n_seen = n_done;
    e.code = code; e.cnt = cnt; e.tag = tag;
    exp_q.push_back(e);
    t_start = cyc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (n_done == n_seen) @(negedge clk);
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] v, input logic [7:0] t);
    return {8'd0, t, v};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ab0;
    clear_model();
    n_abort = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && dead == 0 && bus_req == 0, "R13 reset state", int'({done, dead, bus_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R7 R9: fitting response
    clear_model();
    req_mem[0] = 32'hA0A0_0001; req_mem[1] = 32'hA1A1_0002;
    rq = '{hdr(16'h1E0F, 8'h07), 32'd5, 32'hD000_0000, 32'hD000_0001, 32'hD000_0002};
    kick(16'h1E0F, 8'h07, 8, 16, 2'd0, 12, "R9 fitting response");
    wait_done();
    chk(wlog.size() >= 5, "R3 write count", wlog.size(), 5);
    if (wlog.size() >= 5) begin
      chk(wlog[0] == {2'd2, hdr(16'h1E0F, 8'h07)}, "R3 header word", int'(wlog[0][31:0]), int'(hdr(16'h1E0F, 8'h07)));
      chk(wlog[1] == {2'd2, 32'd4}, "R3 length word", int'(wlog[1][31:0]), 4);
      chk(wlog[2] == {2'd2, 32'hA0A0_0001}, "R3 payload 0", int'(wlog[2][31:0]), int'(32'hA0A0_0001));
      chk(wlog[3] == {2'd2, 32'hA1A1_0002}, "R3 payload 1", int'(wlog[3][31:0]), int'(32'hA1A1_0002));
      chk(wlog[4] == {2'd0, 32'h8000_0000}, "R3 go write", int'(wlog[4][33:32]), 0);
    end
    chk(n_ack == 5, "R7 acknowledge count", n_ack, 5);
    for (int i = 0; i < 3; i++)
      chk(rsp_mem[i] == 32'hD000_0000 + 32'(i), "R9 stored word", int'(rsp_mem[i]), i);
    chk(stat_t.size() >= 3 && stat_t[2] - stat_t[1] == POLL + 2, "R4 poll spacing",
        (stat_t.size() >= 3) ? stat_t[2] - stat_t[1] : -1, POLL + 2);

    // R9: truncation and drain
    clear_model();
    rsp_mem[2] = 32'h5A5A_5A5A;
    rq = '{hdr(16'h0042, 8'h01), 32'd7, 32'hE0, 32'hE1, 32'hE2, 32'hE3, 32'hE4};
    kick(16'h0042, 8'h01, 4, 8, 2'd0, 8, "R9 truncated response");
    wait_done();
    chk(rsp_mem[0] == 32'hE0 && rsp_mem[1] == 32'hE1, "R9 truncated words", int'(rsp_mem[1]), 32'hE1);
    chk(rsp_mem[2] == 32'h5A5A_5A5A, "R9 beyond capacity untouched", int'(rsp_mem[2]), 32'h5A5A_5A5A);
    chk(rq.size() == 0 && n_ack == 7, "R7 drained all words", n_ack, 7);

    // R3 R9: empty request, bare response
    clear_model();
    rq = '{hdr(16'h0001, 8'h00), 32'd2};
    kick(16'h0001, 8'h00, 0, 4, 2'd0, 0, "R9 empty payload");
    wait_done();
    chk(wlog.size() >= 2 && wlog[1] == {2'd2, 32'd2}, "R3 length of empty request",
        (wlog.size() >= 2) ? int'(wlog[1][31:0]) : -1, 2);

    // R6 header mismatch
    clear_model();
    ab0 = n_abort;
    rq = '{hdr(16'h0042, 8'h09), 32'd3, 32'h1};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R6 header mismatch");
    wait_done();
    chk(n_abort == ab0 + 1, "R11 abort on mismatch", n_abort - ab0, 1);

    // R8 length bounds
    clear_model();
    rq = '{hdr(16'h0042, 8'h01), 32'd1};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R8 length below 2");
    wait_done();
    clear_model();
    rq = '{hdr(16'h0042, 8'h01), 32'd70};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R8 length above max");
    wait_done();

    // R2 pre-send checks
    clear_model();
    m_busy = 1;
    kick(16'h0042, 8'h01, 4, 8, 2'd1, 0, "R2 busy before send");
    wait_done();
    chk(wlog.size() == 1 && wlog[0] == {2'd0, 32'h1}, "R2 busy sends only abort", wlog.size(), 1);
    clear_model();
    m_err = 1;
    kick(16'h0042, 8'h01, 4, 8, 2'd2, 0, "R2 error before send");
    wait_done();
    chk(wlog.size() == 1, "R2 error sends only abort", wlog.size(), 1);

    // R4 error while polling
    clear_model();
    m_err_go = 1;
    rq = '{hdr(16'h0042, 8'h01), 32'd2};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R4 error while polling");
    wait_done();

    // R5 timeout
    clear_model();
    m_never = 1;
    rq = '{hdr(16'h0042, 8'h01), 32'd2};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R5 response timeout");
    wait_done();
    chk(t_done - t_start >= TMO, "R5 timeout duration", t_done - t_start, TMO);
    chk(stat_t.size() >= 3 && stat_t[2] - stat_t[1] == POLL + 2, "R4 poll cadence",
        (stat_t.size() >= 3) ? stat_t[2] - stat_t[1] : -1, POLL + 2);

    // R12 cancel
    clear_model();
    m_never = 1;
    ab0 = n_abort;
    rq = '{hdr(16'h0042, 8'h01), 32'd2};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R12 cancel");
    repeat (40) @(negedge clk);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    wait_done();
    chk(t_done - t_start < TMO / 2, "R12 cancel is prompt", t_done - t_start, TMO / 2);
    chk(n_abort == ab0 + 1, "R12 cancel aborts", n_abort - ab0, 1);

    // R10 ready dropped before last acknowledge
    clear_model();
    m_kill = 1;
    rq = '{hdr(16'h0042, 8'h01), 32'd4, 32'h11, 32'h22};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R10 ready lost");
    wait_done();

    // R10 final error
    clear_model();
    m_drain_err = 1;
    rq = '{hdr(16'h0042, 8'h01), 32'd3, 32'h33};
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R10 final error");
    wait_done();

    // R1 invalid sizes
    clear_model();
    kick(16'h0042, 8'h01, 6, 8, 2'd3, 0, "R1 ragged request");
    wait_done();
    chk(wlog.size() == 0 && stat_t.size() == 0, "R1 no access", wlog.size() + stat_t.size(), 0);
    kick(16'h0042, 8'h01, 4, 2, 2'd3, 0, "R1 tiny response buffer");
    wait_done();
    kick(16'h0042, 8'h01, 36, 8, 2'd3, 0, "R1 oversized request");
    wait_done();

    // R11 abort never settles
    clear_model();
    m_err = 1; m_stuck = 1;
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R11 stuck abort");
    wait_done();
    chk(dead == 1'b1, "R11 dead flag", int'(dead), 1);
    chk(t_done - t_start >= TMO, "R11 abort deadline", t_done - t_start, TMO);
    clear_model();
    kick(16'h0042, 8'h01, 0, 8, 2'd2, 0, "R11 dead refuses");
    wait_done();
    chk(wlog.size() == 0 && stat_t.size() == 0, "R11 dead makes no access", wlog.size() + stat_t.size(), 0);
    chk(t_done - t_start <= 2, "R11 dead completes at once", t_done - t_start, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R13 every start completed", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule